// File: doc/BRIEF.md
# Tagged Sort and Absorb Network

This block turns a small bag of tagged values into an ordered set. It takes four 3-bit entries, each with a valid flag, and holds them in a register bank. On every clock it sends the bank through one column of two-input compare cells. Columns with cells on the pairs (0,1) and (2,3) alternate with columns that have one cell on the pair (1,2). Each cell puts the smaller valid word on its low side and the larger one on its high side. When a cell sees two equal valid words, it keeps one copy and turns the other into a null, an entry whose flag is cleared. A null ranks above every valid word, so nulls travel to the high positions. A null that leaves a cell has its data field forced to zero.

A one-cycle `start` loads the parallel inputs and the network begins working. The network stops once one column of each kind in a row has left the bank unchanged. At that point every adjacent pair is already ordered, free of repeats and with nulls last, and `done` pulses for one cycle. The outputs show the register bank directly and hold their value until the next accepted start. A start that arrives while the network is working is ignored.

Top module: `sort_absorb_net`

## Requirements
- R1: While reset is held low and in the first cycle after it, `done` is 0, every output flag is 0 and every output data field is 0.
- R2: When `done` is high, the valid output entries are the distinct values among the valid inputs, in strictly ascending order. Entry 0, in the lowest bits, holds the smallest value, and entry i sits at bits [3i+2:3i].
- R3: When `done` is high, every entry above the last valid one has flag 0 and data 0, and no valid entry follows a null.
- R4: Two or more valid inputs with the same value produce exactly one valid output carrying that value, so the number of valid outputs equals the number of distinct valid input values.
- R5: The data field of an input whose flag is 0 has no effect on the outputs at completion.
- R6: `done` is high for exactly one cycle per accepted start.
- R7: A `start` that arrives before the current run completes is ignored. The result and the single `done` pulse belong to the first load.
- R8: After `done`, the outputs hold their value until the next accepted start, whatever the data inputs do.
- R9: A run never completes in the cycle after its start. An input that is already ordered, free of repeats, with nulls last and null data zero, raises `done` exactly two cycles after the start is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load pulse, accepted only while idle |
| in_data | input | 12 | Four 3-bit input words, entry i at bits [3i+2:3i] |
| in_tag | input | 4 | Valid flag per input entry, 1 marks a real value |
| done | output | 1 | One-cycle completion pulse |
| out_data | output | 12 | Four 3-bit result words, same layout as the input |
| out_tag | output | 4 | Valid flag per result entry |

## Verification
The hardest case to reach from the ports is a late absorb. Here two equal words only meet after an earlier column has already pushed a larger value past them, so the new null appears in the middle of the bank and has to travel upward through further columns. Random draws rarely produce this. The stimulus therefore mixes in draws from a narrow value range, where repeats are common, and adds directed inputs of the form 2,1,1,0 that force this ordering. A second hard case is a start that arrives mid-run. The bench issues it one cycle after a reversed input, which is certain to be still working, and then checks the result against the first load.

// File: rtl/sa_pkg.sv
// Shared types for the tagged sort/absorb network.
// Assumes: nothing beyond the standard types.
package sa_pkg;

    // Which column of cells a pass uses: pairs starting at even or odd index.
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } pass_phase_e;

endpackage

// File: rtl/sa_cell.sv
// sa_cell: two-input compare/absorb cell, purely combinational.
// Low side (lo_*) receives the smaller valid word, high side (hi_*) the larger.
// Equal valid words: one copy stays low, the high side becomes a null.
// Nulls rank above every valid word; any null output carries data zero.
// Assumes: flag 1 = valid entry, flag 0 = null.
module sa_cell #(
    parameter int DW = 3
) (
    input  logic [DW-1:0] a_data,
    input  logic          a_tag,
    input  logic [DW-1:0] b_data,
    input  logic          b_tag,
    output logic [DW-1:0] lo_data,
    output logic          lo_tag,
    output logic [DW-1:0] hi_data,
    output logic          hi_tag
);

    logic same;
    logic a_above;

    // Word relations that steer the cell.
    always_comb begin
        same    = (a_data == b_data);
        a_above = (a_data > b_data);
    end

    // Pick the action from both flags and the word relations.
    always_comb begin
        lo_data = '0;
        lo_tag  = 1'b0;
        hi_data = '0;
        hi_tag  = 1'b0;
        case ({a_tag, b_tag})
            2'b11: begin
                if (same) begin
                    lo_data = a_data;
                    lo_tag  = 1'b1;
                end else if (a_above) begin
                    lo_data = b_data;
                    lo_tag  = 1'b1;
                    hi_data = a_data;
                    hi_tag  = 1'b1;
                end else begin
                    lo_data = a_data;
                    lo_tag  = 1'b1;
                    hi_data = b_data;
                    hi_tag  = 1'b1;
                end
            end
            2'b10: begin
                lo_data = a_data;
                lo_tag  = 1'b1;
            end
            2'b01: begin
                lo_data = b_data;
                lo_tag  = 1'b1;
            end
            default: begin
                lo_data = '0;
                lo_tag  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sa_pass.sv
// sa_pass: one column of sa_cell instances over the whole entry bank.
// ODD = 0 pairs (0,1),(2,3),...; ODD = 1 pairs (1,2),(3,4),...
// Entries not covered by a cell pass through unchanged.
// Assumes: entry i at bits [i*DW +: DW], flag i at bit i.
module sa_pass #(
    parameter int N_ENT = 4,
    parameter int DW    = 3,
    parameter int ODD   = 0
) (
    input  logic [N_ENT*DW-1:0] d_in,
    input  logic [N_ENT-1:0]    t_in,
    output logic [N_ENT*DW-1:0] d_out,
    output logic [N_ENT-1:0]    t_out
);

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        localparam bit LEAD  = ((i % 2) == ODD) && (i + 1 < N_ENT);
        localparam bit TRAIL = (i >= 1) && (((i - 1) % 2) == ODD);
        if (LEAD) begin : g_cell
            sa_cell #(.DW(DW)) cell_i (
                .a_data (d_in[i*DW +: DW]),
                .a_tag  (t_in[i]),
                .b_data (d_in[(i+1)*DW +: DW]),
                .b_tag  (t_in[i+1]),
                .lo_data(d_out[i*DW +: DW]),
                .lo_tag (t_out[i]),
                .hi_data(d_out[(i+1)*DW +: DW]),
                .hi_tag (t_out[i+1])
            );
        end else if (!TRAIL) begin : g_thru
            assign d_out[i*DW +: DW] = d_in[i*DW +: DW];
            assign t_out[i]          = t_in[i];
        end
    end

endmodule

// File: rtl/sort_absorb_net.sv
// sort_absorb_net: register-per-pass network that orders tagged entries
// and absorbs repeats. Even and odd columns alternate each cycle. The run
// ends once an even and an odd column in a row change nothing; then done
// pulses for one cycle and the bank holds until the next accepted start.
// Assumes: synchronous active-low reset; start is ignored while running.
module sort_absorb_net #(
    parameter int N_ENT = 4,
    parameter int DW    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [N_ENT*DW-1:0] in_data,
    input  logic [N_ENT-1:0]    in_tag,
    output logic                done,
    output logic [N_ENT*DW-1:0] out_data,
    output logic [N_ENT-1:0]    out_tag
);
    import sa_pkg::*;

    localparam int BW = N_ENT * DW;

    logic [BW-1:0]    data_q;
    logic [N_ENT-1:0] tag_q;
    logic             busy_q;
    pass_phase_e      phase_q;
    logic             quiet_q;
    logic             done_q;

    logic [BW-1:0]    ev_data, od_data, nx_data;
    logic [N_ENT-1:0] ev_tag,  od_tag,  nx_tag;
    logic             changed;

    sa_pass #(.N_ENT(N_ENT), .DW(DW), .ODD(0)) pass_even_i (
        .d_in (data_q),
        .t_in (tag_q),
        .d_out(ev_data),
        .t_out(ev_tag)
    );

    sa_pass #(.N_ENT(N_ENT), .DW(DW), .ODD(1)) pass_odd_i (
        .d_in (data_q),
        .t_in (tag_q),
        .d_out(od_data),
        .t_out(od_tag)
    );

    // Select this cycle's column and detect whether it alters the bank.
    always_comb begin
        if (phase_q == PH_ODD) begin
            nx_data = od_data;
            nx_tag  = od_tag;
        end else begin
            nx_data = ev_data;
            nx_tag  = ev_tag;
        end
        changed = (nx_data != data_q) || (nx_tag != tag_q);
    end

    // Load, step the bank one column per cycle, and finish on two quiet passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            tag_q   <= '0;
            busy_q  <= 1'b0;
            phase_q <= PH_EVEN;
            quiet_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    data_q  <= in_data;
                    tag_q   <= in_tag;
                    busy_q  <= 1'b1;
                    phase_q <= PH_EVEN;
                    quiet_q <= 1'b0;
                end
            end else begin
                data_q  <= nx_data;
                tag_q   <= nx_tag;
                phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
                quiet_q <= !changed;
                if (!changed && quiet_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done     = done_q;
    assign out_data = data_q;
    assign out_tag  = tag_q;

endmodule

// File: rtl/sa_net_chk.sv
// sa_net_chk: property checker for sort_absorb_net, attached by bind.
// Assumes: busy is the network's internal running flag.
module sa_net_chk #(
    parameter int N_ENT = 4,
    parameter int DW    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [N_ENT*DW-1:0] out_data,
    input logic [N_ENT-1:0]    out_tag
);

    // R1: reset clears the completion flag and the bank.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!done && out_tag == '0 && out_data == '0));

    // R6: done never lasts two cycles.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an idle bank without a start keeps its outputs.
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(out_data) && $stable(out_tag)));

    // R9: no completion in the cycle after an accepted start.
    a_r9_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !done);

    for (genvar i = 0; i < N_ENT; i++) begin : g_null
        // R3: a null entry at completion carries zero data.
        a_r3_null_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !out_tag[i]) |-> (out_data[i*DW +: DW] == '0));
    end

    for (genvar i = 0; i + 1 < N_ENT; i++) begin : g_ord
        // R2: valid neighbours rise strictly; R3: no valid entry after a null.
        a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
            (done && out_tag[i+1]) |->
                (out_tag[i] && (out_data[i*DW +: DW] < out_data[(i+1)*DW +: DW])));
    end

endmodule

bind sort_absorb_net sa_net_chk #(.N_ENT(N_ENT), .DW(DW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy_q),
    .done    (done),
    .out_data(out_data),
    .out_tag (out_tag)
);

// File: tb/sort_absorb_net_tb.sv
// Self-checking bench: directed corner cases plus seeded random loads.
module sort_absorb_net_tb_top;

    localparam int CLK_P = 10;
    localparam int N     = 4;
    localparam int DW    = 3;
    localparam int BW    = N * DW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [BW-1:0] in_data;
    logic [N-1:0]  in_tag;
    logic          done;
    logic [BW-1:0] out_data;
    logic [N-1:0]  out_tag;

    int n_checks = 0;
    int n_fails  = 0;
    int last_lat = 0;

    always #(CLK_P/2) clk = ~clk;

    sort_absorb_net #(.N_ENT(N), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_data(in_data), .in_tag(in_tag),
        .done(done), .out_data(out_data), .out_tag(out_tag)
    );

    // One check: count it, report a failure with actual and expected.
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected result: distinct valid values ascending, nulls zeroed at the top.
    task automatic ref_model(input logic [BW-1:0] d, input logic [N-1:0] t,
                             output logic [BW-1:0] ed, output logic [N-1:0] et);
        logic [(1<<DW)-1:0] seen;
        int k;
        seen = '0;
        for (int i = 0; i < N; i++)
            if (t[i]) seen[d[i*DW +: DW]] = 1'b1;
        ed = '0;
        et = '0;
        k = 0;
        for (int v = 0; v < (1<<DW); v++) begin
            if (seen[v]) begin
                ed[k*DW +: DW] = DW'(v);
                et[k] = 1'b1;
                k++;
            end
        end
    endtask

    // Load one input set, wait for done, check result, pulse width and hold.
    task automatic run(input logic [BW-1:0] d, input logic [N-1:0] t, input string tag_r);
        logic [BW-1:0] ed;
        logic [N-1:0]  et;
        int cyc;
        ref_model(d, t, ed, et);
        @(negedge clk);
        in_data = d;
        in_tag  = t;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        last_lat = cyc;
        chk(done, "R6 done seen", 32'(done), 32'd1);
        chk(out_tag == et, {tag_r, " R2 R4 tags"}, 32'(out_tag), 32'(et));
        chk(out_data == ed, {tag_r, " R2 R3 data"}, 32'(out_data), 32'(ed));
        in_data = ~d;
        @(negedge clk);
        chk(!done, "R6 single cycle", 32'(done), 32'd0);
        chk(out_data == ed && out_tag == et, "R8 hold after done", 32'(out_data), 32'(ed));
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fails);
        $finish;
    end

    initial begin
        logic [BW-1:0] d;
        logic [N-1:0]  t;
        logic [BW-1:0] ed;
        logic [N-1:0]  et;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; in_data = '1; in_tag = '1;
        repeat (3) @(negedge clk);
        chk(!done && out_tag == '0 && out_data == '0, "R1 reset state", 32'(out_data), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && out_tag == '0, "R1 after reset", 32'(out_tag), 32'd0);

        // R9: already canonical input completes two cycles after start.
        run({3'd0, 3'd5, 3'd3, 3'd1}, 4'b0111, "R9 sorted");
        chk(last_lat == 3, "R9 latency", 32'(last_lat), 32'd3);
        // R4: all equal collapses to one entry.
        run({3'd6, 3'd6, 3'd6, 3'd6}, 4'b1111, "R4 all equal");
        // Reverse order of distinct values.
        run({3'd1, 3'd3, 3'd5, 3'd7}, 4'b1111, "R2 reversed");
        // Late absorb: 2,1,1,0 (entry 0 = 2).
        run({3'd0, 3'd1, 3'd1, 3'd2}, 4'b1111, "R4 late absorb");
        run({3'd1, 3'd2, 3'd1, 3'd2}, 4'b1111, "R4 pairs");
        // R5: nulls with nonzero data, including values equal to valid ones.
        run({3'd7, 3'd4, 3'd4, 3'd2}, 4'b0101, "R5 null data");
        run({3'd5, 3'd5, 3'd5, 3'd5}, 4'b0000, "R5 all null");
        run({3'd0, 3'd3, 3'd6, 3'd0}, 4'b1000, "R3 single top");

        // R7: second start mid-run is ignored.
        ref_model({3'd0, 3'd2, 3'd4, 3'd6}, 4'b1111, ed, et);
        @(negedge clk);
        in_data = {3'd0, 3'd2, 3'd4, 3'd6}; in_tag = 4'b1111; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        in_data = {3'd7, 3'd7, 3'd7, 3'd7}; in_tag = 4'b0001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk(out_data == ed && out_tag == et, "R7 start ignored", 32'(out_data), 32'(ed));
        @(negedge clk);
        chk(!done, "R7 one done pulse", 32'(done), 32'd0);
        repeat (4) @(negedge clk);
        chk(!done, "R7 no second done", 32'(done), 32'd0);

        // Random loads; half from a narrow range to force repeats.
        for (int n = 0; n < 300; n++) begin
            t = N'($urandom);
            for (int i = 0; i < N; i++)
                d[i*DW +: DW] = (n % 2 == 0) ? DW'($urandom % 3) : DW'($urandom);
            run(d, t, "R2 R3 R4 R5 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule